// File: doc/BRIEF.md
# Conditional DSP Arithmetic Execution Unit

This unit is one execution slot of a small processor datapath. It does three kinds of integer arithmetic of the sort signal-processing code needs: a signed addition that clamps at the ends of the 32-bit range instead of wrapping, a signed 16×16 multiply-accumulate, and a packed-byte sum of absolute differences with an optional accumulate. For the multiply-accumulate, either the upper or the lower halfword of each source can be picked on its own. The sum of absolute differences is the usual inner step of block-matching motion search.

Each operation is issued with a 4-bit condition field and the current N, Z, C and V flags. The operation retires only when the condition holds; otherwise it leaves no architectural effect. Outputs are registered once. A result, a write-enable and a valid strobe appear one clock after the issuing cycle. A sticky saturation flag records any clamping or accumulate overflow and holds it until software clears it.

Top module: `dspx_unit`

## Requirements
- R1: With opcode 2'b00 (clamping add), the result is the signed sum of `opnd_a` and `opnd_b`. A positive overflow yields 0x7FFFFFFF and sets the sticky flag; for example, 0x70000000 + 0x7FFFFFFF gives 0x7FFFFFFF.
- R2: In the clamping add, a negative overflow yields 0x80000000 and sets the sticky flag.
- R3: With opcode 2'b01 (halfword multiply-accumulate), `hsel_a`=1 selects bits [31:16] of `opnd_a` and 0 selects bits [15:0]; `hsel_b` does the same for `opnd_b`. The two selected halfwords are multiplied as signed values, and the product is added to `opnd_c`.
- R4: If the multiply-accumulate addition overflows the signed 32-bit range, the result wraps modulo 2^32 and the sticky flag is set.
- R5: With opcode 2'b10, each operand is four unsigned byte lanes. The result is the sum of the four lane absolute differences, zero-extended, and `opnd_c` is ignored.
- R6: With opcode 2'b11, the byte-lane sum is added to `opnd_c` modulo 2^32, and this never sets the sticky flag.
- R7: Condition codes 0 to 15 mean EQ, NE, CS, CC, MI, PL, VS, VC, HI, LS, GE, LT, GT, LE, always and never. They are tested against `flags`, where bit 3 is N, bit 2 is Z, bit 1 is C and bit 0 is V.
- R8: When the condition fails, `out_we` is low, `out_result` keeps its previous value and the sticky flag does not change.
- R9: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `out_we` is never high without `out_valid`.
- R10: The sticky flag stays set until a cycle with `sat_clr` high. A saturation event in that same cycle wins over the clear.
- R11: Synchronous active-high reset clears `out_valid`, `out_we`, `out_result` and `sat_sticky`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue strobe for one operation |
| op | input | 2 | Operation select |
| hsel_a | input | 1 | Upper (1) or lower (0) halfword of operand A for multiply |
| hsel_b | input | 1 | Upper (1) or lower (0) halfword of operand B for multiply |
| cond | input | 4 | Condition code |
| flags | input | 4 | Current N, Z, C, V flags |
| opnd_a | input | 32 | First source operand |
| opnd_b | input | 32 | Second source operand |
| opnd_c | input | 32 | Accumulate operand |
| sat_clr | input | 1 | Clear the sticky saturation flag |
| out_valid | output | 1 | Result strobe, one cycle after issue |
| out_we | output | 1 | Register write-enable, condition passed |
| out_result | output | 32 | Operation result |
| sat_sticky | output | 1 | Sticky saturation flag |

## Verification
A sticky clear and a new saturation event can fall in the same cycle, so the two functions collide there. The bench provokes this on purpose: every vector in its table issues with `sat_clr` high. The flag must then read back as exactly that vector's own clamp or overflow outcome, which shows that the event beats the clear and that an earlier event leaks nothing into the result. Directed steps then separate the two: a clear with no issue, an issue with no clear, and a saturating operation whose condition fails.

// File: rtl/dspx_pkg.sv
package dspx_pkg;

    typedef enum logic [1:0] {
        OP_QADD = 2'd0,
        OP_SMLA = 2'd1,
        OP_SAD  = 2'd2,
        OP_SADA = 2'd3
    } dsp_op_e;

    typedef enum logic [3:0] {
        CC_EQ = 4'h0, CC_NE = 4'h1, CC_CS = 4'h2, CC_CC = 4'h3,
        CC_MI = 4'h4, CC_PL = 4'h5, CC_VS = 4'h6, CC_VC = 4'h7,
        CC_HI = 4'h8, CC_LS = 4'h9, CC_GE = 4'hA, CC_LT = 4'hB,
        CC_GT = 4'hC, CC_LE = 4'hD, CC_AL = 4'hE, CC_NV = 4'hF
    } cond_e;

    localparam int FLAG_N = 3;
    localparam int FLAG_Z = 2;
    localparam int FLAG_C = 1;
    localparam int FLAG_V = 0;

endpackage

// File: rtl/dspx_cond.sv
module dspx_cond
    import dspx_pkg::*;
(
    input  logic [3:0] cond,
    input  logic [3:0] flags,
    output logic       pass
);
    logic n, z, c, v;

    always_comb begin
        n = flags[FLAG_N];
        z = flags[FLAG_Z];
        c = flags[FLAG_C];
        v = flags[FLAG_V];
        unique case (cond_e'(cond))
            CC_EQ: pass = z;
            CC_NE: pass = !z;
            CC_CS: pass = c;
            CC_CC: pass = !c;
            CC_MI: pass = n;
            CC_PL: pass = !n;
            CC_VS: pass = v;
            CC_VC: pass = !v;
            CC_HI: pass = c && !z;
            CC_LS: pass = !c || z;
            CC_GE: pass = (n == v);
            CC_LT: pass = (n != v);
            CC_GT: pass = !z && (n == v);
            CC_LE: pass = z || (n != v);
            CC_AL: pass = 1'b1;
            default: pass = 1'b0;
        endcase
    end
endmodule

// File: rtl/dspx_qadd.sv
module dspx_qadd #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         clamp
);
    localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0] wide;

    always_comb begin
        wide  = {a[W-1], a} + {b[W-1], b};
        clamp = wide[W] != wide[W-1];
        if (!clamp)      sum = wide[W-1:0];
        else if (wide[W]) sum = NEG_MIN;
        else              sum = POS_MAX;
    end
endmodule

// File: rtl/dspx_smla.sv
module dspx_smla #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    input  logic         hi_a,
    input  logic         hi_b,
    output logic [W-1:0] acc,
    output logic         ovf
);
    localparam int HW = W / 2;

    logic signed [HW-1:0] half_a, half_b;
    logic signed [W-1:0]  prod;
    logic        [W:0]    wide;

    always_comb begin
        half_a = hi_a ? a[W-1:HW] : a[HW-1:0];
        half_b = hi_b ? b[W-1:HW] : b[HW-1:0];
        prod   = W'(half_a) * W'(half_b);
        wide   = {prod[W-1], prod} + {c[W-1], c};
        ovf    = wide[W] != wide[W-1];
        acc    = wide[W-1:0];
    end
endmodule

// File: rtl/dspx_sad.sv
module dspx_sad #(
    parameter int W    = 32,
    parameter int LANE = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] sad,
    output logic [W-1:0] sad_acc
);
    localparam int LANES = W / LANE;

    logic [LANE-1:0] diff [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE-1:0] la, lb;
        assign la = a[g*LANE +: LANE];
        assign lb = b[g*LANE +: LANE];
        assign diff[g] = (la > lb) ? (la - lb) : (lb - la);
    end

    always_comb begin
        sad = '0;
        for (int i = 0; i < LANES; i++) begin
            sad = sad + W'(diff[i]);
        end
        sad_acc = sad + c;
    end
endmodule

// File: rtl/dspx_unit.sv
module dspx_unit
    import dspx_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [1:0]   op,
    input  logic         hsel_a,
    input  logic         hsel_b,
    input  logic [3:0]   cond,
    input  logic [3:0]   flags,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [W-1:0] opnd_c,
    input  logic         sat_clr,
    output logic         out_valid,
    output logic         out_we,
    output logic [W-1:0] out_result,
    output logic         sat_sticky
);
    typedef struct packed {
        logic         valid;
        logic         we;
        logic         sticky;
        logic [W-1:0] result;
    } unit_st_t;

    unit_st_t st_d, st_q;

    logic         cond_ok;
    logic [W-1:0] qadd_res, smla_res, sad_res, sada_res, pick_res;
    logic         qadd_sat, smla_ovf, pick_evt;

    dspx_cond i_cond (
        .cond  (cond),
        .flags (flags),
        .pass  (cond_ok)
    );

    dspx_qadd #(.W(W)) i_qadd (
        .a     (opnd_a),
        .b     (opnd_b),
        .sum   (qadd_res),
        .clamp (qadd_sat)
    );

    dspx_smla #(.W(W)) i_smla (
        .a    (opnd_a),
        .b    (opnd_b),
        .c    (opnd_c),
        .hi_a (hsel_a),
        .hi_b (hsel_b),
        .acc  (smla_res),
        .ovf  (smla_ovf)
    );

    dspx_sad #(.W(W), .LANE(8)) i_sad (
        .a       (opnd_a),
        .b       (opnd_b),
        .c       (opnd_c),
        .sad     (sad_res),
        .sad_acc (sada_res)
    );

    always_comb begin
        unique case (dsp_op_e'(op))
            OP_QADD: begin pick_res = qadd_res; pick_evt = qadd_sat; end
            OP_SMLA: begin pick_res = smla_res; pick_evt = smla_ovf; end
            OP_SAD:  begin pick_res = sad_res;  pick_evt = 1'b0;     end
            default: begin pick_res = sada_res; pick_evt = 1'b0;     end
        endcase

        st_d       = st_q;
        st_d.valid = in_valid;
        st_d.we    = in_valid && cond_ok;
        if (sat_clr) st_d.sticky = 1'b0;
        if (in_valid && cond_ok) begin
            st_d.result = pick_res;
            if (pick_evt) st_d.sticky = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid  = st_q.valid;
    assign out_we     = st_q.we;
    assign out_result = st_q.result;
    assign sat_sticky = st_q.sticky;
endmodule

// File: rtl/dspx_unit_chk.sv
module dspx_unit_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [1:0]   op,
    input logic [3:0]   cond,
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic         sat_clr,
    input logic         out_valid,
    input logic         out_we,
    input logic [W-1:0] out_result,
    input logic         sat_sticky
);
    a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r9_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r9_we_needs_valid: assert property (@(posedge clk) disable iff (rst)
        out_we |-> out_valid);

    a_r7_never_writes: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cond == 4'hF) |=> !out_we);

    a_r7_always_writes: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cond == 4'hE) |=> out_we);

    a_r8_idle_holds_result: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_result));

    a_r1_no_positive_wrap: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'b00 && cond == 4'hE && !opnd_a[W-1] && !opnd_b[W-1])
        |=> !out_result[W-1]);

    a_r10_clear_alone: assert property (@(posedge clk) disable iff (rst)
        (sat_clr && !in_valid) |=> !sat_sticky);

    a_r10_sticky_keeps: assert property (@(posedge clk) disable iff (rst)
        (sat_sticky && !sat_clr) |=> sat_sticky);

    a_r11_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_we && !sat_sticky && out_result == '0));
endmodule

bind dspx_unit dspx_unit_chk #(.W(W)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .op         (op),
    .cond       (cond),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .sat_clr    (sat_clr),
    .out_valid  (out_valid),
    .out_we     (out_we),
    .out_result (out_result),
    .sat_sticky (sat_sticky)
);

// File: tb/test_dspx_unit.sv
`timescale 1ns/1ps
module test_dspx_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, hsel_a, hsel_b, sat_clr;
    logic [1:0]  op;
    logic [3:0]  cond, flags;
    logic [31:0] opnd_a, opnd_b, opnd_c;
    logic        out_valid, out_we, sat_sticky;
    logic [31:0] out_result;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    dspx_unit i_dspx_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
        .hsel_a(hsel_a), .hsel_b(hsel_b), .cond(cond), .flags(flags),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c), .sat_clr(sat_clr),
        .out_valid(out_valid), .out_we(out_we), .out_result(out_result),
        .sat_sticky(sat_sticky)
    );

    typedef struct packed {
        logic [23:0] tag;
        logic [1:0]  op;
        logic        ha;
        logic        hb;
        logic [3:0]  cc;
        logic [3:0]  fl;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] c;
        logic        we;
        logic [31:0] res;
        logic        sat;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VECS [NV] = '{
        '{"R1 ", 2'd0, 1'b0, 1'b0, 4'hE, 4'h0, 32'h70000000, 32'h7FFFFFFF, 32'h0, 1'b1, 32'h7FFFFFFF, 1'b1},
        '{"R1 ", 2'd0, 1'b0, 1'b0, 4'hE, 4'h0, 32'h00000005, 32'h00000007, 32'h0, 1'b1, 32'h0000000C, 1'b0},
        '{"R2 ", 2'd0, 1'b0, 1'b0, 4'hE, 4'h0, 32'h80000000, 32'hFFFFFFFF, 32'h0, 1'b1, 32'h80000000, 1'b1},
        '{"R2 ", 2'd0, 1'b0, 1'b0, 4'hE, 4'h0, 32'hFFFFFFFE, 32'h00000001, 32'h0, 1'b1, 32'hFFFFFFFF, 1'b0},
        '{"R3 ", 2'd1, 1'b0, 1'b0, 4'hE, 4'h0, 32'h00030002, 32'h0005FFFD, 32'hA, 1'b1, 32'h00000004, 1'b0},
        '{"R3 ", 2'd1, 1'b1, 1'b0, 4'hE, 4'h0, 32'h00030002, 32'h0005FFFD, 32'hA, 1'b1, 32'h00000001, 1'b0},
        '{"R3 ", 2'd1, 1'b0, 1'b1, 4'hE, 4'h0, 32'h00030002, 32'h0005FFFD, 32'hA, 1'b1, 32'h00000014, 1'b0},
        '{"R4 ", 2'd1, 1'b1, 1'b1, 4'hE, 4'h0, 32'h80000000, 32'h80000000, 32'h40000000, 1'b1, 32'h80000000, 1'b1},
        '{"R5 ", 2'd2, 1'b0, 1'b0, 4'hE, 4'h0, 32'h10FF0080, 32'h2000FF7F, 32'h12345678, 1'b1, 32'h0000020F, 1'b0},
        '{"R5 ", 2'd2, 1'b0, 1'b0, 4'hE, 4'h0, 32'hFFFFFFFF, 32'h00000000, 32'h0, 1'b1, 32'h000003FC, 1'b0},
        '{"R6 ", 2'd3, 1'b0, 1'b0, 4'hE, 4'h0, 32'h10FF0080, 32'h2000FF7F, 32'h100, 1'b1, 32'h0000030F, 1'b0},
        '{"R6 ", 2'd3, 1'b0, 1'b0, 4'hE, 4'h0, 32'hFF000000, 32'h00000000, 32'hFFFFFFF0, 1'b1, 32'h000000EF, 1'b0},
        '{"R7 ", 2'd0, 1'b0, 1'b0, 4'h0, 4'h4, 32'h1, 32'h1, 32'h0, 1'b1, 32'h2, 1'b0},
        '{"R7 ", 2'd0, 1'b0, 1'b0, 4'h0, 4'h0, 32'h1, 32'h1, 32'h0, 1'b0, 32'h2, 1'b0},
        '{"R7 ", 2'd0, 1'b0, 1'b0, 4'h1, 4'h0, 32'h1, 32'h1, 32'h0, 1'b1, 32'h2, 1'b0},
        '{"R7 ", 2'd0, 1'b0, 1'b0, 4'h2, 4'h2, 32'h1, 32'h1, 32'h0, 1'b1, 32'h2, 1'b0},
        '{"R7 ", 2'd0, 1'b0, 1'b0, 4'h3, 4'h2, 32'h1, 32'h1, 32'h0, 1'b0, 32'h2, 1'b0},
        '{"R7 ", 2'd0, 1'b0, 1'b0, 4'h4, 4'h8, 32'h1, 32'h1, 32'h0, 1'b1, 32'h2, 1'b0},
        '{"R7 ", 2'd0, 1'b0, 1'b0, 4'h5, 4'h8, 32'h1, 32'h1, 32'h0, 1'b0, 32'h2, 1'b0},
        '{"R7 ", 2'd0, 1'b0, 1'b0, 4'h6, 4'h1, 32'h1, 32'h1, 32'h0, 1'b1, 32'h2, 1'b0},
        '{"R7 ", 2'd0, 1'b0, 1'b0, 4'h7, 4'h0, 32'h1, 32'h1, 32'h0, 1'b1, 32'h2, 1'b0},
        '{"R7 ", 2'd0, 1'b0, 1'b0, 4'h8, 4'h2, 32'h1, 32'h1, 32'h0, 1'b1, 32'h2, 1'b0},
        '{"R7 ", 2'd0, 1'b0, 1'b0, 4'h8, 4'h6, 32'h1, 32'h1, 32'h0, 1'b0, 32'h2, 1'b0},
        '{"R7 ", 2'd0, 1'b0, 1'b0, 4'h9, 4'h6, 32'h1, 32'h1, 32'h0, 1'b1, 32'h2, 1'b0},
        '{"R7 ", 2'd0, 1'b0, 1'b0, 4'hA, 4'h9, 32'h1, 32'h1, 32'h0, 1'b1, 32'h2, 1'b0},
        '{"R7 ", 2'd0, 1'b0, 1'b0, 4'hB, 4'h9, 32'h1, 32'h1, 32'h0, 1'b0, 32'h2, 1'b0},
        '{"R7 ", 2'd0, 1'b0, 1'b0, 4'hB, 4'h8, 32'h1, 32'h1, 32'h0, 1'b1, 32'h2, 1'b0},
        '{"R7 ", 2'd0, 1'b0, 1'b0, 4'hC, 4'h0, 32'h1, 32'h1, 32'h0, 1'b1, 32'h2, 1'b0},
        '{"R7 ", 2'd0, 1'b0, 1'b0, 4'hC, 4'h4, 32'h1, 32'h1, 32'h0, 1'b0, 32'h2, 1'b0},
        '{"R7 ", 2'd0, 1'b0, 1'b0, 4'hD, 4'h4, 32'h1, 32'h1, 32'h0, 1'b1, 32'h2, 1'b0},
        '{"R7 ", 2'd0, 1'b0, 1'b0, 4'hE, 4'hF, 32'h1, 32'h1, 32'h0, 1'b1, 32'h2, 1'b0},
        '{"R7 ", 2'd0, 1'b0, 1'b0, 4'hF, 4'hF, 32'h1, 32'h1, 32'h0, 1'b0, 32'h2, 1'b0}
    };

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge with outputs registered.
    task automatic issue(input logic [1:0] o, input logic ha, input logic hb,
                         input logic [3:0] cc, input logic [3:0] fl,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] c, input logic clr);
        op = o; hsel_a = ha; hsel_b = hb; cond = cc; flags = fl;
        opnd_a = a; opnd_b = b; opnd_c = c; sat_clr = clr; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; sat_clr = 1'b0;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; sat_clr = 1'b0; op = 2'd0;
        hsel_a = 1'b0; hsel_b = 1'b0; cond = 4'hE; flags = 4'h0;
        opnd_a = '0; opnd_b = '0; opnd_c = '0;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", "valid", {31'b0, out_valid}, 32'h0);
        check("R11", "we", {31'b0, out_we}, 32'h0);
        check("R11", "result", out_result, 32'h0);
        check("R11", "sticky", {31'b0, sat_sticky}, 32'h0);
        rst = 1'b0;
        @(negedge clk);

        // Table walk: each vector issues with sat_clr high, so the sticky flag
        // reads back that vector's own event (event beats clear, R10).
        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].op, VECS[i].ha, VECS[i].hb, VECS[i].cc, VECS[i].fl,
                  VECS[i].a, VECS[i].b, VECS[i].c, 1'b1);
            check("R9", "valid", {31'b0, out_valid}, 32'h1);
            check(string'(VECS[i].tag), "we", {31'b0, out_we}, {31'b0, VECS[i].we});
            if (VECS[i].we)
                check(string'(VECS[i].tag), "result", out_result, VECS[i].res);
            check("R10", "sticky", {31'b0, sat_sticky}, {31'b0, VECS[i].sat && VECS[i].we});
        end

        // R9: idle cycle drops valid
        @(negedge clk);
        check("R9", "idle valid", {31'b0, out_valid}, 32'h0);
        check("R9", "idle we", {31'b0, out_we}, 32'h0);

        // R8: failed condition keeps the previous result
        issue(2'd0, 1'b0, 1'b0, 4'hE, 4'h0, 32'h00000010, 32'h00000020, 32'h0, 1'b1);
        check("R8", "baseline result", out_result, 32'h00000030);
        issue(2'd2, 1'b0, 1'b0, 4'h0, 4'h0, 32'hFFFFFFFF, 32'h0, 32'h0, 1'b0);
        check("R8", "fail we", {31'b0, out_we}, 32'h0);
        check("R8", "held result", out_result, 32'h00000030);

        // R8: failed saturating add leaves a clear sticky flag clear
        issue(2'd0, 1'b0, 1'b0, 4'hF, 4'h0, 32'h70000000, 32'h7FFFFFFF, 32'h0, 1'b0);
        check("R8", "sticky untouched", {31'b0, sat_sticky}, 32'h0);

        // R10: sticky persists across a clean op, then clears on its own
        issue(2'd0, 1'b0, 1'b0, 4'hE, 4'h0, 32'h80000000, 32'h80000000, 32'h0, 1'b0);
        check("R2", "neg clamp", out_result, 32'h80000000);
        check("R10", "sticky set", {31'b0, sat_sticky}, 32'h1);
        issue(2'd2, 1'b0, 1'b0, 4'hE, 4'h0, 32'h01010101, 32'h0, 32'h0, 1'b0);
        check("R5", "lane sum", out_result, 32'h00000004);
        check("R10", "sticky kept", {31'b0, sat_sticky}, 32'h1);
        sat_clr = 1'b1;
        @(negedge clk);
        sat_clr = 1'b0;
        check("R10", "sticky cleared", {31'b0, sat_sticky}, 32'h0);

        // R4: accumulate overflow on the negative side sets sticky
        issue(2'd1, 1'b0, 1'b1, 4'hE, 4'h0, 32'h00007FFF, 32'h7FFF0000, 32'h80000000, 1'b0);
        check("R4", "wrap result", out_result, 32'hBFFF0001);
        check("R4", "no overflow sticky", {31'b0, sat_sticky}, 32'h0);
        issue(2'd1, 1'b0, 1'b0, 4'hE, 4'h0, 32'h00000001, 32'h0000FFFF, 32'h80000000, 1'b0);
        check("R4", "neg wrap result", out_result, 32'h7FFFFFFF);
        check("R4", "neg wrap sticky", {31'b0, sat_sticky}, 32'h1);

        // R11: reset mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R11", "sticky after reset", {31'b0, sat_sticky}, 32'h0);
        check("R11", "result after reset", out_result, 32'h0);

        summary();
    end
endmodule